// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block holds the two hidden 32-bit result registers of a processor's integer multiply and divide path, called HI and LO here. A start strobe carries a 6-bit function code and two operands (`rs`, `rt`). A multiply writes the 64-bit product across the pair, with the upper word in HI. A divide puts the quotient in LO and the remainder in HI. Four move operations are the only way to load HI or LO from `rs`, or to return one of them on `rd_data` for the register file.

Multiply and divide run iteratively, one bit per clock, and `busy` stays high while they run. The surrounding pipeline stalls on `busy`. A move-from request that arrives during an operation is held inside the unit. It is answered as soon as the result has been written, so the value returned is always the new one.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After a synchronous active-low reset, HI and LO read back as zero and `busy`, `rd_valid` and `rd_data` are zero.
- R2: Function 011000 (signed multiply) writes the two's-complement 64-bit product of `rs` and `rt`, with bits 63:32 in HI and bits 31:0 in LO.
- R3: Function 011001 (unsigned multiply) writes the unsigned 64-bit product, split the same way as in R2.
- R4: Function 011010 (signed divide) writes the quotient, truncated toward zero, to LO and the remainder, which takes the sign of the dividend, to HI. The 32-bit result wraps, so 0x80000000 divided by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R5: Function 011011 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: An accepted multiply, or a divide with a nonzero divisor, holds `busy` high for exactly 33 cycles after the accepting edge. The new HI and LO values are in place by the edge at which `busy` falls.
- R7: A divide with `rt` equal to zero leaves HI and LO unchanged and never raises `busy`.
- R8: Function 010001 loads HI from `rs` and function 010011 loads LO from `rs`. Both complete at the accepting edge, without raising `busy` or `rd_valid`.
- R9: When idle, function 010000 returns HI and function 010010 returns LO on `rd_data`, with `rd_valid` high in the cycle after the accepting edge.
- R10: A move-from request made while `busy` is high is held. `busy` stays high until the request is answered, which happens at the first edge after the result has been written; `busy` falls at that same edge. Only one such request is held at a time.
- R11: Any other start while `busy` is high is ignored, and so is a start with an unlisted function code. HI and LO keep their values in both cases.
- R12: `rd_data` holds its last value in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled on each rising edge |
| func | input | 6 | Function code of the request |
| rs | input | 32 | First operand; the dividend, or the value for a move-to |
| rt | input | 32 | Second operand; the divisor |
| busy | output | 1 | An operation or a held read is in progress |
| rd_valid | output | 1 | `rd_data` carries a freshly returned HI or LO value |
| rd_data | output | 32 | Value returned by a move-from operation |

## Verification
The collision that matters is a move-from that arrives while a multiply or divide is still running. This includes a request that lands on the very edge at which the result is written. The bench issues reads a few cycles into an operation and at its final cycle, and it mixes in move-to and second multiply requests that must be dropped. A behavioural model advanced on every edge predicts `busy`, `rd_valid` and `rd_data` for each cycle. That prediction shows whether the held read returned the new result, and whether it came exactly one cycle after completion.

// File: rtl/hilo_pkg.sv
// Package: function codes shared by the HI/LO unit, its checker and the bench.
// Assumes the 6-bit code space; codes not listed here are treated as no-ops.
package hilo_pkg;
    typedef enum logic [5:0] {
        FN_MFHI  = 6'b010000,
        FN_MTHI  = 6'b010001,
        FN_MFLO  = 6'b010010,
        FN_MTLO  = 6'b010011,
        FN_MULT  = 6'b011000,
        FN_MULTU = 6'b011001,
        FN_DIV   = 6'b011010,
        FN_DIVU  = 6'b011011
    } hilo_fn_e;
endpackage

// File: rtl/hilo_mul_iter.sv
// Iterative unsigned shift-add multiplier, one multiplier bit per clock.
// Assumes unsigned magnitudes; sign correction is done by the caller.
// done pulses for one cycle after W steps, with the product held on prod.
module hilo_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [2*W-1:0] prod
);
    localparam int CW = $clog2(W);

    logic           run;
    logic [CW-1:0]  cnt;
    logic [W-1:0]   mcand;
    logic [2*W-1:0] acc;
    logic [W:0]     psum;

    // Add the multiplicand to the upper half when the current multiplier bit is set.
    always_comb psum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);

    // Load operands, then shift the partial product right once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            cnt   <= '0;
            mcand <= '0;
            acc   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                mcand <= a;
                acc   <= {{W{1'b0}}, b};
                cnt   <= '0;
                run   <= 1'b1;
            end else if (run) begin
                acc <= {psum, acc[W-1:1]};
                if (cnt == CW'(W-1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign prod = acc;
endmodule

// File: rtl/hilo_div_iter.sv
// Iterative unsigned restoring divider, one quotient bit per clock.
// Assumes the divisor is nonzero and operands are magnitudes; the caller fixes signs.
// done pulses for one cycle after W steps, with quo and rem held.
module hilo_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W);

    logic          run;
    logic [CW-1:0] cnt;
    logic [W-1:0]  dvs;
    logic [W:0]    trial;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb trial = {rem, quo[W-1]} - {1'b0, dvs};

    // Load operands, then produce one quotient bit per step, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            cnt  <= '0;
            dvs  <= '0;
            quo  <= '0;
            rem  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                dvs <= b;
                quo <= a;
                rem <= '0;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= {rem[W-2:0], quo[W-1]};
                    quo <= {quo[W-2:0], 1'b0};
                end
                if (cnt == CW'(W-1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hilo_muldiv_unit.sv
// HI/LO multiply-divide unit: owns HI and LO, runs multiply and divide
// iteratively, and serves the four move operations. Starts are accepted only
// when idle; one move-from arriving while busy is held and answered after
// the result is written. Assumes the pipeline stalls while busy is high.
module hilo_muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [5:0]   func,
    input  logic [W-1:0] rs,
    input  logic [W-1:0] rt,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    import hilo_pkg::*;

    logic [W-1:0]   hi_q, lo_q;
    logic           running, pend, pend_hi;
    logic           neg_p, neg_r;
    logic           is_mul, is_div, is_sgn, is_mf, accept;
    logic           mul_load, div_load, mul_done, div_done;
    logic [W-1:0]   a_mag, b_mag, quo, rem;
    logic [2*W-1:0] prod;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
        return (sgn && v[W-1]) ? -v : v;
    endfunction

    assign busy = running || pend;

    // Decode the request and form unsigned operand magnitudes.
    always_comb begin
        is_mul   = (func == FN_MULT) || (func == FN_MULTU);
        is_div   = (func == FN_DIV)  || (func == FN_DIVU);
        is_sgn   = (func == FN_MULT) || (func == FN_DIV);
        is_mf    = (func == FN_MFHI) || (func == FN_MFLO);
        accept   = start && !busy;
        mul_load = accept && is_mul;
        div_load = accept && is_div && (rt != '0);
        a_mag    = magnitude(rs, is_sgn);
        b_mag    = magnitude(rt, is_sgn);
    end

    hilo_mul_iter #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(mul_load),
        .a(a_mag), .b(b_mag), .done(mul_done), .prod(prod)
    );

    hilo_div_iter #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load),
        .a(a_mag), .b(b_mag), .done(div_done), .quo(quo), .rem(rem)
    );

    // Update HI/LO, track the running operation and the held read, and answer reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            running  <= 1'b0;
            pend     <= 1'b0;
            pend_hi  <= 1'b0;
            neg_p    <= 1'b0;
            neg_r    <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (mul_done) begin
                {hi_q, lo_q} <= neg_p ? -prod : prod;
                running      <= 1'b0;
            end
            if (div_done) begin
                lo_q    <= neg_p ? -quo : quo;
                hi_q    <= neg_r ? -rem : rem;
                running <= 1'b0;
            end
            if (!running && pend) begin
                rd_valid <= 1'b1;
                rd_data  <= pend_hi ? hi_q : lo_q;
                pend     <= 1'b0;
            end
            if (mul_load || div_load) begin
                running <= 1'b1;
                neg_p   <= is_sgn && (rs[W-1] ^ rt[W-1]);
                neg_r   <= is_sgn && rs[W-1];
            end
            if (accept) begin
                if (func == FN_MTHI) hi_q <= rs;
                if (func == FN_MTLO) lo_q <= rs;
                if (is_mf) begin
                    rd_valid <= 1'b1;
                    rd_data  <= (func == FN_MFHI) ? hi_q : lo_q;
                end
            end
            if (start && busy && !pend && is_mf) begin
                pend    <= 1'b1;
                pend_hi <= (func == FN_MFHI);
            end
        end
    end
endmodule

// File: rtl/hilo_muldiv_checker.sv
// Checker for the HI/LO unit: port-level timing properties, bound to every instance.
// Assumes synchronous active-low reset held for at least one edge.
module hilo_muldiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [5:0]   func,
    input logic [W-1:0] rt,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] rd_data
);
    import hilo_pkg::*;

    a_r6_mul_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (func == FN_MULT || func == FN_MULTU)) |=> busy);

    a_r7_divzero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (func == FN_DIV || func == FN_DIVU) && rt == '0) |=> !busy);

    a_r8_move_to_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (func == FN_MTHI || func == FN_MTLO)) |=> (!busy && !rd_valid));

    a_r9_move_from_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (func == FN_MFHI || func == FN_MFLO)) |=> rd_valid);

    a_r12_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .rt(rt),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/hilo_muldiv_unit_test.sv
// Bench: a behavioural per-edge model predicts busy/rd_valid/rd_data, compared
// every cycle; directed sequences also read results back and check them.
module hilo_muldiv_unit_test;
    import hilo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  func = 6'b000000;
    logic [31:0] rs = '0, rt = '0;
    logic        busy, rd_valid;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit checking = 1'b0;

    int          m_cnt;
    bit          m_pend, m_pend_hi, m_rdv;
    logic [31:0] m_hi, m_lo, m_rdd, m_res_hi, m_res_lo;

    hilo_muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func), .rs(rs), .rt(rt),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] ref_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        logic [63:0] r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r = '0;
        case (f)
            FN_MULT:  r = sa * sb;
            FN_MULTU: r = {32'b0, a} * {32'b0, b};
            FN_DIV:   begin r[31:0] = 32'(sa / sb); r[63:32] = 32'(sa % sb); end
            FN_DIVU:  begin r[31:0] = a / b; r[63:32] = a % b; end
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic bit m_busy();
        return (m_cnt > 0) || m_pend;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin : model
        bit was_busy, pb;
        logic [63:0] e;
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_pend_hi = 0; m_rdv = 0;
            m_hi = '0; m_lo = '0; m_rdd = '0; m_res_hi = '0; m_res_lo = '0;
        end else begin
            was_busy = m_busy();
            pb = m_pend;
            m_rdv = 0;
            if (m_cnt == 0 && m_pend) begin
                m_rdv = 1; m_rdd = m_pend_hi ? m_hi : m_lo; m_pend = 0;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin m_hi = m_res_hi; m_lo = m_res_lo; end
            end
            if (start && !was_busy) begin
                case (func)
                    FN_MULT, FN_MULTU: begin
                        e = ref_op(func, rs, rt); m_res_hi = e[63:32]; m_res_lo = e[31:0]; m_cnt = LAT;
                    end
                    FN_DIV, FN_DIVU: if (rt != 0) begin
                        e = ref_op(func, rs, rt); m_res_hi = e[63:32]; m_res_lo = e[31:0]; m_cnt = LAT;
                    end
                    FN_MTHI: m_hi = rs;
                    FN_MTLO: m_lo = rs;
                    FN_MFHI: begin m_rdv = 1; m_rdd = m_hi; end
                    FN_MFLO: begin m_rdv = 1; m_rdd = m_lo; end
                    default: ;
                endcase
            end else if (start && was_busy && !pb && (func == FN_MFHI || func == FN_MFLO)) begin
                m_pend = 1; m_pend_hi = (func == FN_MFHI);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && checking) begin
            check({cur_req, " busy"}, {31'b0, busy}, {31'b0, m_busy()});
            check({cur_req, " rd_valid"}, {31'b0, rd_valid}, {31'b0, m_rdv});
            check({cur_req, " rd_data"}, rd_data, m_rdd);
        end
    end

    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; func = f; rs = a; rt = b;
        @(negedge clk);
        start = 1'b0; func = 6'b000000;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (m_busy() && guard < 200) begin @(negedge clk); guard++; end
    endtask

    task automatic read_chk(input bit hi, input logic [31:0] exp, input string tag);
        issue(hi ? FN_MFHI : FN_MFLO, '0, '0);
        check({tag, " read valid"}, {31'b0, rd_valid}, 32'd1);
        check({tag, hi ? " HI" : " LO"}, rd_data, exp);
    endtask

    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [63:0] e;
        e = ref_op(f, a, b);
        cur_req = tag;
        issue(f, a, b);
        wait_idle();
        read_chk(1'b1, e[63:32], tag);
        read_chk(1'b0, e[31:0], tag);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] held;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        // R1: reset state
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        read_chk(1'b1, 32'd0, "R1");
        read_chk(1'b0, 32'd0, "R1");

        // R8: move-to operations
        cur_req = "R8";
        issue(FN_MTHI, 32'h1234_5678, '0);
        check("R8 busy after mthi", {31'b0, busy}, 32'd0);
        issue(FN_MTLO, 32'hCAFE_F00D, '0);
        read_chk(1'b1, 32'h1234_5678, "R8");
        read_chk(1'b0, 32'hCAFE_F00D, "R8");
        // R12: data held once valid drops
        held = rd_data;
        @(negedge clk);
        check("R12 valid low", {31'b0, rd_valid}, 32'd0);
        check("R12 data held", rd_data, held);

        // R2 signed multiply
        run_op(FN_MULT, 32'hFFFF_FFF9, 32'd9, "R2");
        run_op(FN_MULT, 32'h8000_0000, 32'h8000_0000, "R2");
        run_op(FN_MULT, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
        run_op(FN_MULT, 32'h7FFF_FFFF, 32'h8000_0000, "R2");
        // R3 unsigned multiply
        run_op(FN_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        run_op(FN_MULTU, 32'h0001_0000, 32'h0001_0000, "R3");
        // R4 signed divide
        run_op(FN_DIV, 32'hFFFF_FFF9, 32'd2, "R4");
        run_op(FN_DIV, 32'd7, 32'hFFFF_FFFE, "R4");
        run_op(FN_DIV, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
        run_op(FN_DIV, 32'd3, 32'd5, "R4");
        // R5 unsigned divide
        run_op(FN_DIVU, 32'hFFFF_FFFF, 32'd7, "R5");
        run_op(FN_DIVU, 32'h8000_0000, 32'h8000_0001, "R5");

        // R6: busy length
        cur_req = "R6";
        issue(FN_MULTU, 32'd6, 32'd7);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R6 busy cycles", n, LAT);
        read_chk(1'b0, 32'd42, "R6");

        // R7: divide by zero
        cur_req = "R7";
        issue(FN_MTHI, 32'hAAAA_5555, '0);
        issue(FN_MTLO, 32'h5555_AAAA, '0);
        issue(FN_DIV, 32'd100, 32'd0);
        check("R7 no busy", {31'b0, busy}, 32'd0);
        issue(FN_DIVU, 32'd100, 32'd0);
        check("R7 no busy divu", {31'b0, busy}, 32'd0);
        read_chk(1'b1, 32'hAAAA_5555, "R7");
        read_chk(1'b0, 32'h5555_AAAA, "R7");

        // R10: held read during a multiply, and one on the final busy cycle
        cur_req = "R10";
        issue(FN_MULT, 32'hFFFF_FFFD, 32'd1000);
        repeat (3) @(negedge clk);
        issue(FN_MFLO, '0, '0);
        n = 0;
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        check("R10 held read valid", {31'b0, rd_valid}, 32'd1);
        check("R10 held read data", rd_data, 32'hFFFF_F448);
        check("R10 busy fell", {31'b0, busy}, 32'd0);
        issue(FN_DIVU, 32'd50, 32'd7);
        repeat (LAT - 2) @(negedge clk);
        issue(FN_MFHI, '0, '0);
        n = 0;
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        check("R10 late read data", rd_data, 32'd1);

        // R11: starts while busy and unknown codes are ignored
        cur_req = "R11";
        issue(FN_MULT, 32'd3, 32'd5);
        issue(FN_MTLO, 32'hDEAD_BEEF, '0);
        issue(FN_MULT, 32'd100, 32'd100);
        wait_idle();
        read_chk(1'b0, 32'd15, "R11");
        read_chk(1'b1, 32'd0, "R11");
        issue(6'b111111, 32'd1, 32'd1);
        check("R11 unknown no busy", {31'b0, busy}, 32'd0);
        read_chk(1'b0, 32'd15, "R11");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule